// File: doc/BRIEF.md
# Signed Fixed-Point Word Resizer

This block converts a signed two's-complement fixed-point word from one split of integer and fraction bits to another. The split on each side is set at compile time. When the output keeps fewer fraction bits than the input, a run-time bit selects how the dropped bits are handled: round to nearest with ties going to an even result, or plain truncation. When the output has fewer integer bits than the rounded value needs, a second run-time bit selects the overflow treatment: clamp to the nearest rail, or keep only the low-order bits.

An overflow flag goes high whenever the rounded value does not fit the output word. The flag works the same way in both overflow modes. A compile-time switch chooses between a purely combinational path and a single output register. The block is meant to sit between arithmetic stages of a fixed-point datapath whose stages use different word formats. An example is a state update loop in which a wide product has to be narrowed before the next accumulate.

Integer widths include the sign bit. A format with `I` integer bits and `F` fraction bits therefore occupies `I+F` bits and represents value = signed word / 2^F.

Top module: `fxr_resize`

## Requirements
- R1: With the output register enabled, while `rst_n` is low at a rising clock edge, the block clears `dout_o` to zero and drops `ovf_o` after that edge, whatever the other inputs are.
- R2: With the output register enabled, the result for an input appears one clock edge after the input was applied and holds until the next edge. With the register disabled, the result follows the input within the same cycle.
- R3: When `rnd_trunc_i` is 0 (nearest) and fraction bits are dropped, the kept value increments by one output LSB if the dropped part is more than half an output LSB. It stays unchanged if the dropped part is less than half an output LSB.
- R4: In nearest mode, a dropped part of exactly half an output LSB increments the kept value only when the kept LSB is 1, so the result LSB is 0.
- R5: When `rnd_trunc_i` is 1 (truncate), the dropped bits are discarded with no increment. For two's-complement values this gives the largest representable value that is not above the input, so a negative input stays negative unless it overflows.
- R6: When `ovf_wrap_i` is 0 (saturate) and the rounded value is out of range, `dout_o` is the largest positive output word for a positive value and the most negative output word for a negative value.
- R7: When `ovf_wrap_i` is 1 (wrap) and the rounded value is out of range, `dout_o` is the low `OUT_INT+OUT_FRAC` bits of the rounded value, so the sign can flip.
- R8: `ovf_o` is 1 exactly when the rounded value lies outside the output range, in either overflow mode. Rounding is applied first, so a round-up that crosses the positive rail raises the flag.
- R9: When `OUT_FRAC >= IN_FRAC`, the input fraction is extended with zeros, no rounding takes place and `rnd_trunc_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| din_i | input | IN_INT+IN_FRAC | Source word, signed, IN_FRAC fraction bits |
| rnd_trunc_i | input | 1 | Rounding select: 0 nearest-even, 1 truncate |
| ovf_wrap_i | input | 1 | Overflow select: 0 saturate, 1 wrap |
| dout_o | output | OUT_INT+OUT_FRAC | Resized word, signed, OUT_FRAC fraction bits |
| ovf_o | output | 1 | Rounded value did not fit the output format |

## Verification
In the registered build, every result is due at the first rising edge after the input changes. The bench therefore drives inputs on the falling edge and samples one time unit after the next rising edge. One step first moves the input on a falling edge and checks that the registered output still shows the earlier result, then checks it again after the edge. A second, combinational build gets its inputs at the same falling edge and is compared within that cycle, without waiting for an edge. The checker delays its view of the inputs by the same number of registers as the design, so each property compares an output with the input that produced it.

// File: rtl/fxr_pkg.sv
// Shared mode encodings for the fixed-point resizer.
// Assumes: a single mode bit per decision, 0 selects the default behaviour.
package fxr_pkg;

    typedef enum logic {
        RND_NEAREST = 1'b0,
        RND_TRUNC   = 1'b1
    } rnd_mode_e;

    typedef enum logic {
        OVF_SAT  = 1'b0,
        OVF_WRAP = 1'b1
    } ovf_mode_e;

endpackage

// File: rtl/fxr_round.sv
// Fraction stage: aligns the source word to OUT_FRAC fraction bits.
// Drops low bits with nearest-even or truncation, or pads with zeros.
// Assumes: IN_INT counts the sign bit. The result carries one guard
// integer bit so that a round-up of the largest value cannot wrap here.
module fxr_round
    import fxr_pkg::*;
#(
    parameter int IN_INT   = 8,
    parameter int IN_FRAC  = 8,
    parameter int OUT_FRAC = 4,
    localparam int IN_W    = IN_INT + IN_FRAC,
    localparam int MID_W   = IN_INT + 1 + OUT_FRAC
) (
    input  logic [IN_W-1:0]  din,
    input  rnd_mode_e        mode,
    output logic [MID_W-1:0] mid
);

    localparam int DROP = IN_FRAC - OUT_FRAC;

    generate
        if (DROP > 0) begin : g_drop
            localparam int KEEP_W = IN_W - DROP;
            logic [KEEP_W-1:0] kept;
            logic              guard;
            logic              sticky;
            logic              bump;

            assign kept  = din[IN_W-1:DROP];
            assign guard = din[DROP-1];

            if (DROP > 1) begin : g_sticky
                assign sticky = |din[DROP-2:0];
            end else begin : g_nosticky
                assign sticky = 1'b0;
            end

            // Increment when above half, or exactly half with an odd kept LSB.
            assign bump = (mode == RND_NEAREST) && guard && (sticky || kept[0]);

            // Sign-extend by one guard bit, then add the rounding increment.
            always_comb mid = {kept[KEEP_W-1], kept} + MID_W'(bump);
        end else begin : g_pad
            localparam int PAD = -DROP;
            if (PAD == 0) begin : g_same
                assign mid = {din[IN_W-1], din};
            end else begin : g_zero
                assign mid = {din[IN_W-1], din, {PAD{1'b0}}};
            end
        end
    endgenerate

endmodule

// File: rtl/fxr_clamp.sv
// Integer stage: fits the aligned value into OUT_W bits.
// Detects overflow and either clamps to a rail or keeps the low bits.
// Assumes: mid is signed and already carries OUT_FRAC fraction bits.
module fxr_clamp
    import fxr_pkg::*;
#(
    parameter int MID_W = 13,
    parameter int OUT_W = 8
) (
    input  logic [MID_W-1:0] mid,
    input  ovf_mode_e        mode,
    output logic [OUT_W-1:0] res,
    output logic             ovf
);

    generate
        if (MID_W > OUT_W) begin : g_narrow
            localparam int HI_W = MID_W - OUT_W + 1;
            logic [HI_W-1:0]  top_bits;
            logic [OUT_W-1:0] rail;

            assign top_bits = mid[MID_W-1:OUT_W-1];

            // Value fits only if all dropped bits copy the new sign bit.
            assign ovf = !((&top_bits) || !(|top_bits));

            // Rail on the side of the true sign.
            assign rail = mid[MID_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                       : {1'b0, {(OUT_W-1){1'b1}}};

            assign res = (ovf && (mode == OVF_SAT)) ? rail : mid[OUT_W-1:0];
        end else begin : g_wide
            assign ovf = 1'b0;
            if (OUT_W == MID_W) begin : g_eq
                assign res = mid;
            end else begin : g_ext
                assign res = {{(OUT_W-MID_W){mid[MID_W-1]}}, mid};
            end
        end
    endgenerate

endmodule

// File: rtl/fxr_resize.sv
// Top: signed fixed-point format converter with run-time rounding and
// overflow selection and an optional output register (REG_OUT).
// Assumes: integer widths include the sign bit; synchronous active-low reset.
module fxr_resize
    import fxr_pkg::*;
#(
    parameter int IN_INT   = 8,
    parameter int IN_FRAC  = 8,
    parameter int OUT_INT  = 4,
    parameter int OUT_FRAC = 4,
    parameter bit REG_OUT  = 1'b1,
    localparam int IN_W    = IN_INT + IN_FRAC,
    localparam int OUT_W   = OUT_INT + OUT_FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din_i,
    input  logic             rnd_trunc_i,
    input  logic             ovf_wrap_i,
    output logic [OUT_W-1:0] dout_o,
    output logic             ovf_o
);

    localparam int MID_W = IN_INT + 1 + OUT_FRAC;

    rnd_mode_e        rmode;
    ovf_mode_e        omode;
    logic [MID_W-1:0] mid;
    logic [OUT_W-1:0] res;
    logic             ovf;

    assign rmode = rnd_mode_e'(rnd_trunc_i);
    assign omode = ovf_mode_e'(ovf_wrap_i);

    fxr_round #(
        .IN_INT  (IN_INT),
        .IN_FRAC (IN_FRAC),
        .OUT_FRAC(OUT_FRAC)
    ) u_round (
        .din (din_i),
        .mode(rmode),
        .mid (mid)
    );

    fxr_clamp #(
        .MID_W(MID_W),
        .OUT_W(OUT_W)
    ) u_clamp (
        .mid (mid),
        .mode(omode),
        .res (res),
        .ovf (ovf)
    );

    generate
        if (REG_OUT) begin : g_reg
            logic [OUT_W-1:0] dout_q;
            logic             ovf_q;

            // Capture the converted word and its flag once per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dout_q <= '0;
                    ovf_q  <= 1'b0;
                end else begin
                    dout_q <= res;
                    ovf_q  <= ovf;
                end
            end

            assign dout_o = dout_q;
            assign ovf_o  = ovf_q;
        end else begin : g_comb
            assign dout_o = res;
            assign ovf_o  = ovf;
        end
    endgenerate

endmodule

// File: rtl/fxr_resize_chk.sv
// Checker for fxr_resize: delays its copy of the inputs to match the
// output latency, then relates outputs to the inputs that produced them.
// Assumes: same parameters as the bound instance.
module fxr_resize_chk #(
    parameter int IN_INT   = 8,
    parameter int IN_FRAC  = 8,
    parameter int OUT_INT  = 4,
    parameter int OUT_FRAC = 4,
    parameter bit REG_OUT  = 1'b1,
    localparam int IN_W    = IN_INT + IN_FRAC,
    localparam int OUT_W   = OUT_INT + OUT_FRAC
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  din_i,
    input logic             rnd_trunc_i,
    input logic             ovf_wrap_i,
    input logic [OUT_W-1:0] dout_o,
    input logic             ovf_o
);

    localparam int DROP = IN_FRAC - OUT_FRAC;
    localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

    logic [IN_W-1:0] d_din;
    logic            d_trunc;
    logic            d_wrap;
    logic            primed;

    generate
        if (REG_OUT) begin : g_dly
            // Input copy aligned with the registered output.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_din   <= '0;
                    d_trunc <= 1'b0;
                    d_wrap  <= 1'b0;
                    primed  <= 1'b0;
                end else begin
                    d_din   <= din_i;
                    d_trunc <= rnd_trunc_i;
                    d_wrap  <= ovf_wrap_i;
                    primed  <= 1'b1;
                end
            end

            // R1
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |=> (dout_o == '0 && !ovf_o))
                else $error("reset_clear_chk");
        end else begin : g_now
            assign d_din   = din_i;
            assign d_trunc = rnd_trunc_i;
            assign d_wrap  = ovf_wrap_i;
            assign primed  = 1'b1;
        end
    endgenerate

    // R6
    sat_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && ovf_o && !d_wrap) |->
            (dout_o == (d_din[IN_W-1] ? MINV : MAXV)))
        else $error("sat_rail_chk");

    // R5
    trunc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && d_trunc && !ovf_o) |-> (dout_o[OUT_W-1] == d_din[IN_W-1]))
        else $error("trunc_sign_chk");

    generate
        if (DROP > 1) begin : g_tie
            // R4
            even_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && !d_trunc && d_din[DROP-1] && (d_din[DROP-2:0] == '0)
                 && (!ovf_o || d_wrap)) |-> !dout_o[0])
                else $error("even_tie_chk");
        end
        if (DROP > 0 && (IN_W - DROP) >= OUT_W) begin : g_wrapbits
            // R7
            wrap_lowbits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && d_trunc && d_wrap) |-> (dout_o == d_din[DROP +: OUT_W]))
                else $error("wrap_lowbits_chk");
        end
    endgenerate

endmodule

bind fxr_resize fxr_resize_chk #(
    .IN_INT  (IN_INT),
    .IN_FRAC (IN_FRAC),
    .OUT_INT (OUT_INT),
    .OUT_FRAC(OUT_FRAC),
    .REG_OUT (REG_OUT)
) u_fxr_resize_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .din_i      (din_i),
    .rnd_trunc_i(rnd_trunc_i),
    .ovf_wrap_i (ovf_wrap_i),
    .dout_o     (dout_o),
    .ovf_o      (ovf_o)
);

// File: tb/fxr_resize_bench.sv
// Bench: registered narrowing build (Q8.8 -> Q4.4) and combinational
// widening build (Q4.4 -> Q6.6), directed corners plus seeded random.
module fxr_resize_bench;

    localparam int A_II = 8, A_IF = 8, A_OI = 4, A_OF = 4;
    localparam int A_IW = A_II + A_IF, A_OW = A_OI + A_OF;
    localparam int B_II = 4, B_IF = 4, B_OI = 6, B_OF = 6;
    localparam int B_IW = B_II + B_IF, B_OW = B_OI + B_OF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [A_IW-1:0] din_a = '0;
    logic [B_IW-1:0] din_b = '0;
    logic            trunc = 1'b0;
    logic            wrap = 1'b0;
    logic [A_OW-1:0] dout_a;
    logic            ovf_a;
    logic [B_OW-1:0] dout_b;
    logic            ovf_b;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fxr_resize #(.IN_INT(A_II), .IN_FRAC(A_IF), .OUT_INT(A_OI), .OUT_FRAC(A_OF),
                 .REG_OUT(1'b1)) u_fxr_resize (
        .clk(clk), .rst_n(rst_n), .din_i(din_a), .rnd_trunc_i(trunc),
        .ovf_wrap_i(wrap), .dout_o(dout_a), .ovf_o(ovf_a));

    fxr_resize #(.IN_INT(B_II), .IN_FRAC(B_IF), .OUT_INT(B_OI), .OUT_FRAC(B_OF),
                 .REG_OUT(1'b0)) u_fxr_resize_wide (
        .clk(clk), .rst_n(rst_n), .din_i(din_b), .rnd_trunc_i(trunc),
        .ovf_wrap_i(wrap), .dout_o(dout_b), .ovf_o(ovf_b));

    // Arithmetic model of the requirements on integer values.
    function automatic void ref_resize(input longint x, input int in_frac,
                                       input int out_w, input int out_frac,
                                       input bit tr, input bit wr,
                                       output longint y, output bit ov);
        longint one = 1;
        longint q, rem, half, hi, lo, m;
        int drop = in_frac - out_frac;
        if (drop > 0) begin
            q    = x >>> drop;
            rem  = x - (q <<< drop);
            half = one <<< (drop - 1);
            if (!tr && (rem > half || (rem == half && q[0]))) q = q + 1;
        end else begin
            q = x <<< (-drop);
        end
        hi = (one <<< (out_w - 1)) - 1;
        lo = -(one <<< (out_w - 1));
        ov = (q > hi) || (q < lo);
        if (ov && !wr) begin
            y = (q > hi) ? hi : lo;
        end else begin
            m = q & ((one <<< out_w) - 1);
            if (m > hi) m = m - (one <<< out_w);
            y = m;
        end
    endfunction

    task automatic check(input string req, input string what,
                         input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic verify_b(input string req);
        longint yb;
        bit     ob;
        ref_resize(longint'($signed(din_b)), B_IF, B_OW, B_OF, trunc, wrap, yb, ob);
        check(req, "wide value", longint'($signed(dout_b)), yb);
        check(req, "wide flag", longint'(ovf_b), longint'(ob));
    endtask

    task automatic verify(input string req);
        longint ya;
        bit     oa;
        ref_resize(longint'($signed(din_a)), A_IF, A_OW, A_OF, trunc, wrap, ya, oa);
        check(req, "narrow value", longint'($signed(dout_a)), ya);
        check(req, "narrow flag", longint'(ovf_a), longint'(oa));
        verify_b(req);
    endtask

    task automatic apply(input logic [A_IW-1:0] a, input logic [B_IW-1:0] b,
                         input bit tr, input bit wr, input string req);
        @(negedge clk);
        din_a = a;
        din_b = b;
        trunc = tr;
        wrap  = wr;
        @(posedge clk);
        #1;
        verify(req);
    endtask

    initial begin
        void'($urandom(32'd20517));
        // R1: reset with non-zero inputs present
        din_a = 16'h7FFF;
        din_b = 8'h55;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset value", longint'(dout_a), 0);
        check("R1", "reset flag", longint'(ovf_a), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: above and below half
        apply(16'h0019, 8'h11, 1'b0, 1'b0, "R3");  // 1.5625 LSB -> 2
        apply(16'h0017, 8'h22, 1'b0, 1'b0, "R3");  // 1.4375 LSB -> 1
        // R4: exact ties go to even
        apply(16'h0018, 8'h33, 1'b0, 1'b0, "R4");  // 1.5 -> 2
        apply(16'h0028, 8'h44, 1'b0, 1'b0, "R4");  // 2.5 -> 2
        apply(16'hFFF8, 8'hF0, 1'b0, 1'b0, "R4");  // -0.5 -> 0
        // R5: truncate floors
        apply(16'hFFF8, 8'hF0, 1'b1, 1'b0, "R5");  // -0.5 -> -1
        apply(16'h001F, 8'h01, 1'b1, 1'b0, "R5");  // 1.9375 -> 1
        // R8: round-up past the positive rail
        apply(16'h07F8, 8'h7F, 1'b0, 1'b0, "R8");  // 127.5 -> 128 -> sat 127
        apply(16'h07F8, 8'h7F, 1'b0, 1'b1, "R8");  // -> wrap -128, flag
        apply(16'h07F8, 8'h7F, 1'b1, 1'b0, "R8");  // truncate -> 127, no flag
        // R6: saturate both rails
        apply(16'h8000, 8'h80, 1'b0, 1'b0, "R6");  // -> -128, flag
        apply(16'h7FFF, 8'h7F, 1'b1, 1'b0, "R6");  // -> 127, flag
        // R7: wrap keeps low bits
        apply(16'h8000, 8'h80, 1'b0, 1'b1, "R7");  // -> 0, flag
        apply(16'h1234, 8'h12, 1'b1, 1'b1, "R7");  // -> 0x23
        // R9: widening path, rounding mode has no effect
        apply(16'h0000, 8'h80, 1'b0, 1'b0, "R9");
        apply(16'h0000, 8'h80, 1'b1, 1'b0, "R9");
        apply(16'h0000, 8'h7F, 1'b0, 1'b1, "R9");
        apply(16'h0000, 8'h7F, 1'b1, 1'b1, "R9");

        // R2: registered output holds until the edge, combinational follows
        apply(16'h0100, 8'h10, 1'b0, 1'b0, "R2");  // narrow result 16
        @(negedge clk);
        din_a = 16'h0200;
        din_b = 8'h20;
        #1;
        check("R2", "held before edge", longint'($signed(dout_a)), 16);
        verify_b("R2");
        @(posedge clk);
        #1;
        verify("R2");

        // R3: seeded random mix, one in three forced to an exact tie
        for (int i = 0; i < 3000; i++) begin
            logic [A_IW-1:0] a;
            logic [B_IW-1:0] b;
            a = A_IW'($urandom);
            b = B_IW'($urandom);
            if (i % 3 == 0) a[3:0] = 4'h8;
            apply(a, b, 1'($urandom), 1'($urandom), "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule